// File: doc/BRIEF.md
# Key-Locked Two-Stage Watchdog Timer

A memory-mapped watchdog built around a 32-bit down-counter. Software programs a reload value, enables counting, and must keep clearing the interrupt, which also reloads the counter, faster than the counter can run out. The first time the counter runs out, the block raises an interrupt and reloads. If the counter runs out again while that interrupt is still pending, the block emits a one-cycle reset request, provided reset is enabled.

Every register except the lock register is protected against stray writes. Writes to the other registers are dropped unless the lock register was last written with the 32-bit key 0x1ACCE551. Reads are always allowed. They are registered and return data one cycle after the read strobe.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the block reads locked (lock reads 1), the control register reads 0, load and count read 0xFFFFFFFF, status reads 0, and `irq` and `rst_req` are low.
- R2: Writing the key 0x1ACCE551 to the lock register (offset 0xC00) unlocks the block, and writing any other value locks it. The lock register reads 1 when locked and 0 when unlocked. While locked, writes to every other register are dropped.
- R3: The registers sit at these offsets: load at 0x000, count at 0x004 (read-only, writes have no effect), control at 0x008, clear at 0x00C, status at 0x014. Read data appears on `bus_rdata` on the cycle after `bus_rd`.
- R4: Control bit 0 enables the reset request. Control bit 1 enables counting and the interrupt output. Bits 31:2 read as zero.
- R5: Any unlocked write to the clear register (0x00C) clears the pending interrupt and reloads the count from the load register. Doing this regularly keeps `irq` and `rst_req` from ever asserting.
- R6: While bit 1 is set, the count drops by one per clock. When the count is zero, the next clock makes the first expiry: the interrupt goes pending and the count reloads. With load value N, `irq` rises N+1 cycles after the reload.
- R7: A load write while counting reloads the count with the new value at once. A load write while stopped leaves the count unchanged.
- R8: An expiry while the interrupt is already pending produces a one-cycle `rst_req` only if control bit 0 is set. The count reloads and the interrupt stays pending.
- R9: With bit 1 clear, the count holds its value and `irq` is low. The pending status (status register reads 1) is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, high while pending and counting is enabled |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench targets the exact expiry cycle for a load value of 5, both for the first expiry and for the second. An off-by-one counter would move `irq` or `rst_req` by a cycle. It tries near-miss keys and writes while locked, including a clear write that must leave a pending interrupt in place. A design with a leaky lock would clear it or change load and control. It checks that a second expiry with reset disabled gives no pulse, that stopping masks `irq` but keeps the status, and that a load write while counting restarts the count where a design that reloads only on clear would not.

// File: rtl/kw_pkg.sv
package kw_pkg;
  localparam int unsigned KW_DATA_W = 32;
  localparam logic [31:0] KW_UNLOCK_KEY = 32'h1ACC_E551;

  localparam int unsigned OFS_LOAD  = 'h000;
  localparam int unsigned OFS_COUNT = 'h004;
  localparam int unsigned OFS_CTRL  = 'h008;
  localparam int unsigned OFS_CLEAR = 'h00C;
  localparam int unsigned OFS_STAT  = 'h014;
  localparam int unsigned OFS_LOCK  = 'hC00;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LOAD, SEL_COUNT, SEL_CTRL, SEL_CLEAR, SEL_STAT, SEL_LOCK
  } kw_sel_e;

  typedef struct packed {
    logic run;     // bit 1: counting and interrupt enable
    logic rst_en;  // bit 0: reset request enable
  } kw_ctrl_t;
endpackage

// File: rtl/kw_regs.sv
module kw_regs
  import kw_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = KW_DATA_W,
  parameter logic [DATA_W-1:0] KEY = DATA_W'(KW_UNLOCK_KEY)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt_q,
  input  logic              pend_q,
  output kw_ctrl_t          ctrl,
  output logic              reload,
  output logic [DATA_W-1:0] reload_val,
  output logic              clr
);
  kw_sel_e           sel;
  logic              locked_q;
  logic [DATA_W-1:0] load_q;
  kw_ctrl_t          ctrl_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_ok;
  logic              load_wr;

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFS_LOAD))  sel = SEL_LOAD;
    else if (bus_addr == ADDR_W'(OFS_COUNT)) sel = SEL_COUNT;
    else if (bus_addr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFS_CLEAR)) sel = SEL_CLEAR;
    else if (bus_addr == ADDR_W'(OFS_STAT))  sel = SEL_STAT;
    else if (bus_addr == ADDR_W'(OFS_LOCK))  sel = SEL_LOCK;
  end

  assign wr_ok      = bus_wr && !locked_q;
  assign load_wr    = wr_ok && (sel == SEL_LOAD);
  assign clr        = wr_ok && (sel == SEL_CLEAR);
  assign reload     = clr || (load_wr && ctrl_q.run);
  assign reload_val = load_wr ? bus_wdata : load_q;
  assign ctrl       = ctrl_q;
  assign bus_rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
      load_q   <= '1;
      ctrl_q   <= '0;
    end else begin
      if (bus_wr && sel == SEL_LOCK) locked_q <= (bus_wdata != KEY);
      if (load_wr) load_q <= bus_wdata;
      if (wr_ok && sel == SEL_CTRL) begin
        ctrl_q.run    <= bus_wdata[1];
        ctrl_q.rst_en <= bus_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      unique case (sel)
        SEL_LOAD:  rdata_q <= load_q;
        SEL_COUNT: rdata_q <= cnt_q;
        SEL_CTRL:  rdata_q <= DATA_W'({ctrl_q.run, ctrl_q.rst_en});
        SEL_STAT:  rdata_q <= DATA_W'(pend_q);
        SEL_LOCK:  rdata_q <= DATA_W'(locked_q);
        default:   rdata_q <= '0;
      endcase
    end
  end

  // R2: a locked bus leaves load and control untouched
  a_r2_locked_load: assert property (@(posedge clk) disable iff (rst)
    (locked_q && bus_wr && sel == SEL_LOAD) |=> $stable(load_q));
  a_r2_locked_ctrl: assert property (@(posedge clk) disable iff (rst)
    (locked_q && bus_wr && sel == SEL_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/kw_counter.sv
module kw_counter
  import kw_pkg::*;
#(
  parameter int unsigned DATA_W = KW_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  kw_ctrl_t          ctrl,
  input  logic              reload,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              clr,
  output logic [DATA_W-1:0] cnt_q,
  output logic              pend_q,
  output logic              irq,
  output logic              rst_req
);
  logic expire;
  logic rst_q;

  // bus reload or clear in the same cycle wins over an expiry
  assign expire  = ctrl.run && !reload && (cnt_q == '0);
  assign irq     = pend_q && ctrl.run;
  assign rst_req = rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= expire && pend_q && ctrl.rst_en;
      if (reload) begin
        cnt_q <= reload_val;
        if (clr) pend_q <= 1'b0;
      end else if (ctrl.run) begin
        if (cnt_q == '0) begin
          cnt_q  <= reload_val;
          pend_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R6: counting steps down by one
  a_r6_decrement: assert property (@(posedge clk) disable iff (rst)
    (ctrl.run && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R9: stopped counter holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !reload) |=> $stable(cnt_q));
  // R5: clear drops the pending flag and reloads
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!pend_q && cnt_q == $past(reload_val)));
  // R8: reset request only with pending interrupt and reset enabled
  a_r8_rst_pending: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> pend_q);
  a_r8_rst_enabled: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(ctrl.rst_en));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kw_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = KW_DATA_W,
  parameter logic [DATA_W-1:0] KEY = DATA_W'(KW_UNLOCK_KEY)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  kw_ctrl_t          ctrl;
  logic              reload;
  logic              clr;
  logic [DATA_W-1:0] reload_val;
  logic [DATA_W-1:0] cnt_q;
  logic              pend_q;

  kw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cnt_q      (cnt_q),
    .pend_q     (pend_q),
    .ctrl       (ctrl),
    .reload     (reload),
    .reload_val (reload_val),
    .clr        (clr)
  );

  kw_counter #(.DATA_W(DATA_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .reload     (reload),
    .reload_val (reload_val),
    .clr        (clr),
    .cnt_q      (cnt_q),
    .pend_q     (pend_q),
    .irq        (irq),
    .rst_req    (rst_req)
  );
endmodule

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_CLR = 12'h00C, A_STAT = 12'h014, A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, rst_req;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog u_keyed_wdog (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req));

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // monitor: compare registered read data with the scoreboard queue
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL monitor got %h exp none", bus_rdata);
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int rst_hits;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(32'(irq), 0, "R1 irq"); check(32'(rst_req), 0, "R1 rst_req");
    rd(A_LOCK, 1, "R1 lock"); rd(A_CTRL, 0, "R1 ctrl");
    rd(A_LOAD, 32'hFFFF_FFFF, "R1 load"); rd(A_CNT, 32'hFFFF_FFFF, "R1 count");
    rd(A_STAT, 0, "R1 status");
    // R2 locked write dropped, key unlocks
    wr(A_LOAD, 5); rd(A_LOAD, 32'hFFFF_FFFF, "R2 locked load");
    wr(A_LOCK, KEY); rd(A_LOCK, 0, "R2 unlocked");
    // R3 offsets, count read-only; R7 stopped load leaves count
    wr(A_LOAD, 5); rd(A_LOAD, 5, "R3 load");
    rd(A_CNT, 32'hFFFF_FFFF, "R7 stopped load");
    wr(A_CNT, 32'h1234); rd(A_CNT, 32'hFFFF_FFFF, "R3 count read-only");
    // R2 relock with other value
    wr(A_LOCK, 0); wr(A_CTRL, 3); rd(A_CTRL, 0, "R2 relocked ctrl");
    wr(A_LOCK, KEY);
    // R4 control bits
    wr(A_CTRL, 32'hFFFF_FFFC); rd(A_CTRL, 0, "R4 reserved");
    wr(A_CTRL, 1); rd(A_CTRL, 1, "R4 bit0");
    wr(A_CTRL, 0);
    // R5 clear reloads
    wr(A_CLR, 1); rd(A_CNT, 5, "R5 reload");
    // R6 first expiry after N+1 cycles
    wr(A_CTRL, 2);
    idle(5); check(32'(irq), 0, "R6 irq early");
    idle(1); check(32'(irq), 1, "R6 irq on time");
    // R9 stop: masked, pending kept, count held
    wr(A_CTRL, 0); check(32'(irq), 0, "R9 irq masked");
    rd(A_STAT, 1, "R9 pending kept");
    rd(A_CNT, 4, "R9 count held"); rd(A_CNT, 4, "R9 count held again");
    // R5 clear
    wr(A_CLR, 1); rd(A_STAT, 0, "R5 status cleared"); rd(A_CNT, 5, "R5 count");
    // R8 escalation
    wr(A_CTRL, 3);
    idle(5); check(32'(irq), 0, "R6 irq early 2");
    idle(1); check(32'(irq), 1, "R6 irq 2");
    idle(5); check(32'(rst_req), 0, "R8 rst early");
    idle(1); check(32'(rst_req), 1, "R8 rst on time");
    idle(1); check(32'(rst_req), 0, "R8 single pulse");
    check(32'(irq), 1, "R8 still pending");
    // R5 keep-alive
    for (int k = 0; k < 8; k++) begin
      wr(A_CLR, 1);
      check(32'({irq, rst_req}), 0, "R5 keepalive");
      idle(1);
      check(32'({irq, rst_req}), 0, "R5 keepalive idle");
    end
    // R8 gated: no pulse without bit 0
    wr(A_CTRL, 2);
    rst_hits = 0;
    for (int k = 0; k < 20; k++) begin
      idle(1);
      if (rst_req) rst_hits++;
    end
    check(rst_hits, 0, "R8 gated reset");
    check(32'(irq), 1, "R6 irq gated run");
    // R7 load while running reloads
    wr(A_CLR, 1); wr(A_LOAD, 20); wr(A_CTRL, 0);
    rd(A_CNT, 19, "R7 running load"); rd(A_LOAD, 20, "R7 load value");
    // R2 locked clear dropped
    wr(A_LOAD, 0); wr(A_CLR, 1); wr(A_CTRL, 2); wr(A_CTRL, 0);
    rd(A_STAT, 1, "R2 pending set");
    wr(A_LOCK, 32'h1ACC_E550); rd(A_LOCK, 1, "R2 near key locks");
    wr(A_CLR, 1); rd(A_STAT, 1, "R2 locked clear dropped");
    wr(A_CTRL, 2); check(32'(irq), 0, "R2 locked ctrl dropped");
    idle(3);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog got hang exp finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule